// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from up to 32 peripheral sources and presents the processor with a single request. The request carries a priority level, a vector number and a flag that says whether the handler should run on the shadow register set. Each source has four pieces of state: a pending flag, an enable bit, a 3-bit level and a 2-bit sub-level. The controller picks one winner from the sources that are pending, enabled and have a nonzero level. The outputs are registered, so the processor sees a stable request one clock after the state that produced it.

Software reaches the state through a word-addressed register port. Each register occupies a 16-byte group. The first word of the group is written directly. The following three words act on the same register: one clears bits, one sets bits and one toggles bits, each only where the written data holds a 1. With these aliases a handler can acknowledge one source without a read-modify-write sequence.

A source whose peripheral keeps its request line high cannot have its flag cleared. The flag comes back on every clock while the line stays asserted. A 3-bit configuration input names the one level whose handlers get the shadow register set; the value 0 gives the shadow register set to every level.

Top module: `icu_top`

## Requirements
- R1: After reset, all registers read as zero and `cpu_ipl`, `cpu_vec` and `cpu_srs` are 0.
- R2: A source competes only when its flag is 1, its enable bit is 1 and its level is nonzero. With no source competing, `cpu_ipl`, `cpu_vec` and `cpu_srs` are all 0.
- R3: `cpu_ipl` equals the highest level among the competing sources.
- R4: Among competing sources at the same level, the one with the higher sub-level wins. If the sub-levels are also equal, the lower source index wins.
- R5: Register groups sit at these byte addresses: control at 0x000 (bit 0 is the mode), flags at 0x010 (bit i is source i), enables at 0x020 (bit i is source i), and the priority of source i at 0x100+16*i (bits [2:0] are the level, bits [4:3] are the sub-level). Within a group, offset +0x0 writes the register, +0x4 clears the bits written as 1, +0x8 sets them and +0xC inverts them. Bits written as 0 through an alias do not change. A read at any of the four offsets returns the register.
- R6: When control bit 0 is 1 (multi-vector mode), `cpu_vec` is the index of the winning source. When control bit 0 is 0, `cpu_vec` is 0.
- R7: A source whose `irq_src` bit is 1 at a clock edge has its flag set at that edge. This takes precedence over a software clear in the same cycle, so a source held active keeps its flag set.
- R8: `cpu_srs` is 1 when a request is present and either `cfg_srs_sel` is 0 or `cfg_srs_sel` equals the requested level. Otherwise `cpu_srs` is 0.
- R9: `cpu_ipl`, `cpu_vec` and `cpu_srs` update at the first clock edge after the register or input change that affects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| irq_src | input | NSRC | Peripheral request lines: a pulse or a held level |
| cfg_srs_sel | input | 3 | Level that uses the shadow register set (0 means all levels) |
| cpu_ipl | output | 3 | Requested level (0 means no request) |
| cpu_vec | output | $clog2(NSRC) | Vector number |
| cpu_srs | output | 1 | Use the shadow register set |

## Verification
When a flag, enable or level bit is stored wrongly, the error shows at the ports one clock later. The request outputs then carry the wrong level or vector, or stay silent, and a read of the affected register returns the wrong value as soon as the write edge has passed. An error in the precedence between an event and a software clear shows on the next read of the flag register. An error in the winner selection shows only when two sources compete: tied levels, tied sub-levels, and a zero-level source that is pending and enabled are the patterns that expose it. An error in the shadow-select decode shows within one clock of a change to the configuration input.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int MAX_SRC = 32;
    localparam int IDX_W   = 5;

    // register group numbers (byte address bits [11:4])
    localparam logic [7:0] GRP_CTRL      = 8'h00;
    localparam logic [7:0] GRP_FLAG      = 8'h01;
    localparam logic [7:0] GRP_EN        = 8'h02;
    localparam logic [7:0] GRP_PRIO_BASE = 8'h10;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_CLR   = 2'd1,
        OP_SET   = 2'd2,
        OP_INV   = 2'd3
    } alias_op_e;

    // layout matches register bits: sub in [4:3], level in [2:0]
    typedef struct packed {
        logic [1:0] sub;
        logic [2:0] lvl;
    } prio_t;

    typedef struct packed {
        logic             valid;
        prio_t            pr;
        logic [IDX_W-1:0] idx;
    } winner_t;

    function automatic logic [31:0] apply_alias(input logic [31:0] cur,
                                                input logic [31:0] d,
                                                input alias_op_e   op);
        case (op)
            OP_CLR:  return cur & ~d;
            OP_SET:  return cur | d;
            OP_INV:  return cur ^ d;
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [11:0]     wr_addr,
    input  logic [31:0]     wr_data,
    input  logic [11:0]     rd_addr,
    output logic [31:0]     rd_data,
    input  logic [NSRC-1:0] irq_src,
    output logic            mvec_q,
    output logic [NSRC-1:0] flag_q,
    output logic [NSRC-1:0] en_q,
    output prio_t           prio_q [NSRC]
);

    logic [7:0] grp_w, grp_r;
    alias_op_e  op;
    logic       wr_hit;
    logic [31:0] flag_w, en_w, flag_nx, en_nx, ctrl_nx;
    logic [NSRC-1:0] flag_d;

    assign grp_w  = wr_addr[11:4];
    assign grp_r  = rd_addr[11:4];
    assign op     = alias_op_e'(wr_addr[3:2]);
    assign wr_hit = wr_en && (wr_addr[1:0] == 2'b00);

    always_comb begin
        flag_w = '0;
        en_w   = '0;
        flag_w[NSRC-1:0] = flag_q;
        en_w[NSRC-1:0]   = en_q;
        flag_nx = apply_alias(flag_w, wr_data, op);
        en_nx   = apply_alias(en_w, wr_data, op);
        ctrl_nx = apply_alias({31'b0, mvec_q}, wr_data, op);
        // peripheral events win over any software write in the same cycle
        if (wr_hit && grp_w == GRP_FLAG)
            flag_d = flag_nx[NSRC-1:0] | irq_src;
        else
            flag_d = flag_q | irq_src;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
            mvec_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (wr_hit && grp_w == GRP_EN)   en_q   <= en_nx[NSRC-1:0];
            if (wr_hit && grp_w == GRP_CTRL) mvec_q <= ctrl_nx[0];
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_prio
        logic [31:0] cur, nxt;
        always_comb begin
            cur      = '0;
            cur[4:0] = prio_q[g];
            nxt      = apply_alias(cur, wr_data, op);
        end
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[g] <= '0;
            else if (wr_hit && grp_w == GRP_PRIO_BASE + 8'(g))
                prio_q[g] <= prio_t'(nxt[4:0]);
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr[1:0] == 2'b00) begin
            case (grp_r)
                GRP_CTRL: rd_data[0] = mvec_q;
                GRP_FLAG: rd_data[NSRC-1:0] = flag_q;
                GRP_EN:   rd_data[NSRC-1:0] = en_q;
                default: begin
                    for (int i = 0; i < NSRC; i++)
                        if (grp_r == GRP_PRIO_BASE + 8'(i))
                            rd_data[4:0] = prio_q[i];
                end
            endcase
        end
    end

endmodule

// File: rtl/icu_arb.sv
module icu_arb
    import icu_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] flag,
    input  logic [NSRC-1:0] en,
    input  prio_t           prio [NSRC],
    output winner_t         win
);

    // ascending scan with a strict compare keeps the lower index on a full tie
    always_comb begin
        win = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (flag[i] && en[i] && prio[i].lvl != 3'd0 &&
                (!win.valid ||
                 {prio[i].lvl, prio[i].sub} > {win.pr.lvl, win.pr.sub})) begin
                win.valid = 1'b1;
                win.pr    = prio[i];
                win.idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int VEC_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [11:0]      wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [11:0]      rd_addr,
    output logic [31:0]      rd_data,
    input  logic [NSRC-1:0]  irq_src,
    input  logic [2:0]       cfg_srs_sel,
    output logic [2:0]       cpu_ipl,
    output logic [VEC_W-1:0] cpu_vec,
    output logic             cpu_srs
);

    logic            mvec_q;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;
    prio_t           prio_q [NSRC];
    winner_t         win;

    icu_regs #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_src(irq_src),
        .mvec_q(mvec_q), .flag_q(flag_q), .en_q(en_q), .prio_q(prio_q)
    );

    icu_arb #(.NSRC(NSRC)) u_arb (
        .flag(flag_q), .en(en_q), .prio(prio_q), .win(win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_ipl <= '0;
            cpu_vec <= '0;
            cpu_srs <= 1'b0;
        end else begin
            cpu_ipl <= win.valid ? win.pr.lvl : 3'd0;
            cpu_vec <= (win.valid && mvec_q) ? win.idx[VEC_W-1:0] : '0;
            cpu_srs <= win.valid &&
                       (cfg_srs_sel == 3'd0 || cfg_srs_sel == win.pr.lvl);
        end
    end

endmodule

// File: rtl/icu_chk.sv
module icu_chk
    import icu_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int VEC_W = $clog2(NSRC)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [11:0]      wr_addr,
    input logic [31:0]      wr_data,
    input logic [NSRC-1:0]  irq_src,
    input logic             mvec_q,
    input logic [NSRC-1:0]  flag_q,
    input logic [NSRC-1:0]  en_q,
    input prio_t            prio_q [NSRC],
    input logic [2:0]       cpu_ipl,
    input logic [VEC_W-1:0] cpu_vec,
    input logic             cpu_srs
);

    logic [NSRC-1:0] lvl_nz;
    logic [NSRC-1:0] elig;

    always_comb begin
        for (int i = 0; i < NSRC; i++) lvl_nz[i] = (prio_q[i].lvl != 3'd0);
        elig = flag_q & en_q & lvl_nz;
    end

    // R2
    pending_raises_req_chk: assert property (@(posedge clk) disable iff (rst)
        (|elig) |=> (cpu_ipl != 3'd0));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|elig) |=> (cpu_ipl == 3'd0 && cpu_vec == '0 && !cpu_srs));

    // R6
    single_vector_chk: assert property (@(posedge clk) disable iff (rst)
        !mvec_q |=> (cpu_vec == '0));

    // R7
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq_src) |=> ((flag_q & $past(irq_src)) == $past(irq_src)));

    // R5
    clear_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 12'h014 && irq_src == '0)
        |=> ((flag_q & $past(wr_data[NSRC-1:0])) == '0));

    // R8
    srs_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_srs |-> (cpu_ipl != 3'd0));

endmodule

bind icu_top icu_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_src(irq_src),
    .mvec_q(mvec_q), .flag_q(flag_q), .en_q(en_q), .prio_q(prio_q),
    .cpu_ipl(cpu_ipl), .cpu_vec(cpu_vec), .cpu_srs(cpu_srs)
);

// File: tb/tb_icu_top.sv
module tb_icu_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 32;
    localparam int VEC_W = $clog2(NSRC);

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en;
    logic [11:0]      wr_addr;
    logic [31:0]      wr_data;
    logic [11:0]      rd_addr;
    logic [31:0]      rd_data;
    logic [NSRC-1:0]  irq_src;
    logic [2:0]       cfg_srs_sel;
    logic [2:0]       cpu_ipl;
    logic [VEC_W-1:0] cpu_vec;
    logic             cpu_srs;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icu_top #(.NSRC(NSRC)) dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_src(irq_src), .cfg_srs_sel(cfg_srs_sel),
        .cpu_ipl(cpu_ipl), .cpu_vec(cpu_vec), .cpu_srs(cpu_srs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; irq_src = '0; cfg_srs_sel = 3'd7;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic out_chk(input string req, input int ipl, input int vec, input int srs);
        chk({req, " ipl"}, 32'(cpu_ipl), 32'(ipl));
        chk({req, " vec"}, 32'(cpu_vec), 32'(vec));
        chk({req, " srs"}, 32'(cpu_srs), 32'(srs));
    endtask

    task automatic t_reset();
        do_reset();
        out_chk("R1 reset outputs", 0, 0, 0);
        rd_chk("R1 ctrl", 12'h000, 0);
        rd_chk("R1 flags", 12'h010, 0);
        rd_chk("R1 enables", 12'h020, 0);
        rd_chk("R1 prio0", 12'h100, 0);
    endtask

    task automatic t_alias();
        do_reset();
        wr(12'h020, 32'hF0F0_0000);
        rd_chk("R5 write", 12'h020, 32'hF0F0_0000);
        wr(12'h028, 32'h0000_000F);
        rd_chk("R5 set", 12'h020, 32'hF0F0_000F);
        wr(12'h024, 32'h00F0_0000);
        rd_chk("R5 clear", 12'h020, 32'hF000_000F);
        wr(12'h02C, 32'hFF00_0000);
        rd_chk("R5 invert", 12'h020, 32'h0F00_000F);
        rd_chk("R5 alias read", 12'h02C, 32'h0F00_000F);
        wr(12'h1F8, 32'h0000_0018);
        rd_chk("R5 prio set sub", 12'h1F0, 32'h18);
    endtask

    task automatic t_elig();
        do_reset();
        wr(12'h150, 32'd3);            // src5 level 3
        wr(12'h018, 32'h20);           // flag 5
        step();
        out_chk("R2 not enabled", 0, 0, 0);
        wr(12'h028, 32'h20);           // enable 5
        chk("R9 not yet", 32'(cpu_ipl), 0);
        step();
        chk("R9 one clock", 32'(cpu_ipl), 3);
        wr(12'h018, 32'h40);           // src6 flag, level 0
        wr(12'h028, 32'h40);
        wr(12'h014, 32'h20);           // clear src5
        step();
        out_chk("R2 level zero ignored", 0, 0, 0);
    endtask

    task automatic t_prio();
        do_reset();
        wr(12'h008, 32'h1);            // multi-vector
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h190, 32'd5);            // src9
        wr(12'h120, 32'd2);            // src2
        wr(12'h2E0, 32'd4);            // src30
        wr(12'h018, 32'h4000_0004);
        step();
        out_chk("R3 highest of 2,4", 4, 30, 0);
        wr(12'h018, 32'h0000_0200);
        step();
        out_chk("R3 higher arrives", 5, 9, 0);
        wr(12'h014, 32'h0000_0200);
        step();
        out_chk("R3 after clear", 4, 30, 0);
    endtask

    task automatic t_tie();
        do_reset();
        wr(12'h008, 32'h1);
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h1C0, 32'h0D);           // src12 level5 sub1
        wr(12'h130, 32'h05);           // src3 level5 sub0
        wr(12'h018, 32'h0000_1008);
        step();
        out_chk("R4 sub-level wins", 5, 12, 0);
        wr(12'h130, 32'h0D);
        step();
        out_chk("R4 lower index wins", 5, 3, 0);
        wr(12'h004, 32'h1);            // back to single vector
        step();
        out_chk("R6 single vector", 5, 0, 0);
    endtask

    task automatic t_persist();
        do_reset();
        @(negedge clk); irq_src[20] = 1'b1;
        step();
        wr(12'h014, 32'h0010_0000);
        rd_chk("R7 held source", 12'h010, 32'h0010_0000);
        @(negedge clk); irq_src[20] = 1'b0;
        wr(12'h014, 32'h0010_0000);
        rd_chk("R7 released clears", 12'h010, 0);
        @(negedge clk);
        irq_src[7] = 1'b1; wr_en = 1'b1; wr_addr = 12'h014; wr_data = 32'h80;
        @(negedge clk);
        irq_src[7] = 1'b0; wr_en = 1'b0;
        rd_chk("R7 event beats clear", 12'h010, 32'h80);
    endtask

    task automatic t_srs();
        do_reset();
        cfg_srs_sel = 3'd6;
        wr(12'h008, 32'h1);
        wr(12'h020, 32'h2);
        wr(12'h110, 32'd6);            // src1 level 6
        wr(12'h018, 32'h2);
        step();
        out_chk("R8 level match", 6, 1, 1);
        @(negedge clk); cfg_srs_sel = 3'd3;
        @(negedge clk);
        chk("R8 level mismatch", 32'(cpu_srs), 0);
        cfg_srs_sel = 3'd0;
        @(negedge clk);
        chk("R8 all levels", 32'(cpu_srs), 1);
        wr(12'h014, 32'h2);
        step();
        out_chk("R8 no request", 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_alias();
        t_elig();
        t_prio();
        t_tie();
        t_persist();
        t_srs();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule